// File: doc/BRIEF.md
# Shift-Register Operand Stack

A four-slot last-in-first-out store for the operands of a small calculator datapath. It has no pointer: the slots form a column of registers. On a push the whole column moves one place down, and on a pop it moves one place up. The only value visible outside is the slot at the head of the column. A 2-bit mode code is sampled on each rising clock edge and selects hold, push or pop.

On a push the incoming word lands in the head slot and the word in the bottom slot is lost. On a pop the bottom slot is refilled with zero, so popping an empty stack keeps returning zero. The block raises no fault for overflow or for an empty pop. The surrounding control is expected to track depth if it needs to. An active-low reset clears every slot at once, without waiting for a clock edge.

Both the data input and the head output are plain, unhandshaked words. The stack accepts a word on every push edge and never stalls its producer. The head output is valid in every cycle, so no back-pressure path exists.

Top module: `opstk_shift_stack`

## Requirements
- R1: While `rst_n` is low, every slot is zero and `top_word` reads 0. This takes effect without a clock edge and also holds in the first cycle after release.
- R2: Mode codes 0 and 1 are both hold. At a rising edge with either code, every slot keeps its value, and any number of hold cycles leaves `top_word` unchanged.
- R3: Mode code 2 is push. After the rising edge, `top_word` equals the `push_data` value sampled at that edge.
- R4: On a push, each slot's previous value moves one place further from the head. The previous bottom value is discarded without any indication. After five pushes of a, b, c, d, e, successive pops show e, d, c, b, then 0.
- R5: Mode code 3 is pop. After the rising edge, `top_word` shows the value that was second from the head, each slot takes the value of its deeper neighbour, and the bottom slot becomes 0.
- R6: A pop while all slots are zero still shifts and leaves `top_word` at 0. No error is produced.
- R7: `mode_sel` and `push_data` act only at the rising edge. Changing them between edges changes neither `top_word` nor the stored contents.
- R8: Up to four pushed words come back in reverse order of their pushes through successive pops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low, clears all slots |
| mode_sel | input | 2 | 0 or 1 hold, 2 push, 3 pop |
| push_data | input | 5 | Word placed at the head on a push |
| top_word | output | 5 | Current head slot |

## Verification
The stack is driven with straight runs of four pushes followed by pops, which separates true reverse ordering from a queue or a stuck head. Five pushes followed by five pops show that the oldest word is dropped and the bottom is refilled with zero rather than with stale data. Pops on an empty stack, long hold runs using both hold codes, and pushes interleaved with pops test the zero-fill and hold paths. A mode pulse between clock edges and a reset pulsed between edges show that control acts only at the edge and that clearing is asynchronous.

// File: rtl/opstk_pkg.sv
package opstk_pkg;

  // Mode codes as seen on mode_sel; both low codes mean hold.
  typedef enum logic [1:0] {
    MC_HOLD_A = 2'd0,
    MC_HOLD_B = 2'd1,
    MC_PUSH   = 2'd2,
    MC_POP    = 2'd3
  } mode_code_e;

  // Decoded column movement.
  typedef struct packed {
    logic sink;   // shift away from the head (push)
    logic rise;   // shift toward the head (pop)
  } col_move_t;

endpackage

// File: rtl/opstk_ctl_decode.sv
module opstk_ctl_decode
  import opstk_pkg::*;
(
  input  logic [1:0] mode_sel,
  output col_move_t  move
);

  always_comb begin
    move = '0;
    unique case (mode_code_e'(mode_sel))
      MC_PUSH:   move.sink = 1'b1;
      MC_POP:    move.rise = 1'b1;
      MC_HOLD_A,
      MC_HOLD_B: move = '0;
      default:   move = '0;
    endcase
  end

endmodule

// File: rtl/opstk_slot.sv
module opstk_slot
  import opstk_pkg::*;
#(
  parameter int WORD_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  col_move_t         move,
  input  logic [WORD_W-1:0] from_above,
  input  logic [WORD_W-1:0] from_below,
  output logic [WORD_W-1:0] q
);

  logic [WORD_W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (move.sink)      q_nxt = from_above;
    else if (move.rise) q_nxt = from_below;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  // R2: no movement keeps this slot unchanged
  p_slot_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!move.sink && !move.rise) |=> $stable(q));

endmodule

// File: rtl/opstk_shift_stack.sv
module opstk_shift_stack
  import opstk_pkg::*;
#(
  parameter int WORD_W = 5,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic [WORD_W-1:0] push_data,
  output logic [WORD_W-1:0] top_word
);

  localparam int LAST = DEPTH - 1;

  col_move_t move;
  logic [DEPTH-1:0][WORD_W-1:0] slot_q;
  logic [DEPTH-1:0][WORD_W-1:0] above_w;
  logic [DEPTH-1:0][WORD_W-1:0] below_w;

  opstk_ctl_decode u_dec (
    .mode_sel (mode_sel),
    .move     (move)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_col
    if (i == 0) begin : g_head
      assign above_w[i] = push_data;
    end else begin : g_inner_up
      assign above_w[i] = slot_q[i-1];
    end
    if (i == LAST) begin : g_floor
      assign below_w[i] = '0;
    end else begin : g_inner_dn
      assign below_w[i] = slot_q[i+1];
    end

    opstk_slot #(.WORD_W(WORD_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .move       (move),
      .from_above (above_w[i]),
      .from_below (below_w[i]),
      .q          (slot_q[i])
    );

    if (i < LAST) begin : g_chk
      // R4: push moves each value one place deeper
      p_push_sink_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd2) |=> (slot_q[i+1] == $past(slot_q[i])));
      // R5: pop moves each value one place up
      p_pop_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd3) |=> (slot_q[i] == $past(slot_q[i+1])));
    end
  end

  assign top_word = slot_q[0];

  // R1: reset holds the head at zero
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (top_word == '0));

  // R3: pushed word appears at the head
  p_push_head_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'd2) |=> (top_word == $past(push_data)));

  // R5 and R6: bottom slot refilled with zero on pop
  p_pop_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'd3) |=> (slot_q[LAST] == '0));

  // R2: hold codes leave the head stable
  p_hold_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel[1] == 1'b0) |=> $stable(top_word));

  // R2, R3, R5: decoder never asks for both directions
  p_dec_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({move.sink, move.rise}));

endmodule

// File: tb/test_opstk_shift_stack.sv
module test_opstk_shift_stack;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic [4:0] push_data = 5'd0;
  logic [4:0] top_word;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int ref_stk [4];

  always #5 clk = ~clk;

  opstk_shift_stack i_opstk_shift_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_sel  (mode_sel),
    .push_data (push_data),
    .top_word  (top_word)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < 4; k++) ref_stk[k] = 0;
  endtask

  task automatic model_apply(input logic [1:0] m, input logic [4:0] d);
    if (m == 2'd2) begin
      for (int k = 3; k > 0; k--) ref_stk[k] = ref_stk[k-1];
      ref_stk[0] = d;
    end else if (m == 2'd3) begin
      for (int k = 0; k < 3; k++) ref_stk[k] = ref_stk[k+1];
      ref_stk[3] = 0;
    end
  endtask

  task automatic step(input logic [1:0] m, input logic [4:0] d, input string req);
    @(negedge clk);
    mode_sel  = m;
    push_data = d;
    @(posedge clk);
    model_apply(m, d);
    #2;
    check(top_word == ref_stk[0], req, top_word, ref_stk[0]);
  endtask

  initial begin
    model_clear();
    #1;
    check(top_word == 0, "R1 async clear", top_word, 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step(2'd0, 5'd9, "R1 after release");

    // R8 LIFO over full depth
    step(2'd2, 5'd3, "R3");
    step(2'd2, 5'd7, "R3");
    step(2'd2, 5'd12, "R3");
    step(2'd2, 5'd30, "R3");
    step(2'd3, 5'd0, "R8 pop 30->12");
    step(2'd3, 5'd0, "R8");
    step(2'd3, 5'd0, "R8");
    check(top_word == 3, "R8 oldest last", top_word, 3);
    step(2'd3, 5'd0, "R6 last pop to zero");

    // R6 pops on empty
    for (int k = 0; k < 3; k++) step(2'd3, 5'd0, "R6");

    // R4 overflow: five pushes, drain
    for (int k = 1; k <= 5; k++) step(2'd2, 5'(k + 16), "R4 push");
    step(2'd3, 5'd0, "R4");
    check(top_word == 20, "R4 second newest", top_word, 20);
    step(2'd3, 5'd0, "R4");
    step(2'd3, 5'd0, "R4");
    check(top_word == 18, "R4 oldest kept", top_word, 18);
    step(2'd3, 5'd0, "R4 dropped word not back");
    check(top_word == 0, "R4 zero fill", top_word, 0);

    // R2 holds with both codes
    step(2'd2, 5'd5, "R3");
    step(2'd2, 5'd11, "R3");
    for (int k = 0; k < 6; k++) step(2'(k % 2), 5'(k + 1), "R2 hold");
    step(2'd3, 5'd0, "R2 deeper intact");
    check(top_word == 5, "R2 deeper intact", top_word, 5);

    // interleaved pattern
    step(2'd2, 5'd21, "R3");
    step(2'd3, 5'd0, "R5");
    step(2'd2, 5'd22, "R3");
    step(2'd2, 5'd23, "R3");
    step(2'd1, 5'd31, "R2");
    step(2'd3, 5'd0, "R5");
    step(2'd3, 5'd0, "R5");

    // R7 mid-cycle mode pulse
    @(negedge clk);
    mode_sel = 2'd2;
    push_data = 5'd31;
    #1;
    check(top_word == ref_stk[0], "R7 no effect between edges", top_word, ref_stk[0]);
    #1;
    mode_sel = 2'd0;
    @(posedge clk);
    #2;
    check(top_word == ref_stk[0], "R7 edge saw hold", top_word, ref_stk[0]);
    step(2'd3, 5'd0, "R7 contents intact");

    // R1 async reset between edges
    step(2'd2, 5'd14, "R3");
    step(2'd2, 5'd15, "R3");
    @(negedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    check(top_word == 0, "R1 clear without edge", top_word, 0);
    model_clear();
    @(negedge clk);
    rst_n = 1'b1;
    step(2'd3, 5'd0, "R1 all slots cleared");
    step(2'd3, 5'd0, "R1");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule